// File: doc/BRIEF.md
# Minimum-Width Ready Line Stretcher

This block drives an active-low ready/interrupt line to a host processor and makes sure each level it puts on the line lasts at least a set number of clock ticks. That holds for the asserted (low) phase and for the deasserted (high) phase. The tick count is computed from two parameters: the clock frequency and a minimum time in microseconds. Surrounding logic sends single-cycle strobes. An assert strobe signals that a transaction has completed. A release strobe withdraws the line. A chip-select event strobe indicates that the host has started a new SPI access. A stop strobe puts the block back into its idle state.

If an assert strobe arrives while the high phase is still shorter than the minimum, the block does not drop it. The request is queued and the line goes low on the cycle the high phase times out. A chip-select event from the host shows that the host has already seen the ready indication. It ends the low phase at once, and the high phase then starts timing from that point. When stretching is switched off, the block falls back to a short pulse of fixed length. The accept output tells the requester, in the same cycle, which of the two paths handled its assert strobe.

Top module: `irq_stretch`

## Requirements
- R1: After reset `irq_n_o` is 1 (deasserted) and `accept_o` is 0. The line is active low: 0 means asserted.
- R2: In stretch mode, with the line high and no phase timer running, an assert strobe drives `irq_n_o` to 0 from the next cycle on. The line stays 0 for exactly T = (CLK_HZ/1_000_000)*MIN_US cycles and then returns to 1.
- R3: Every stretch-mode rise of the line starts a high phase of T cycles. An assert strobe that arrives during this phase is queued, and the line falls exactly T cycles after it rose.
- R4: When a high phase times out with nothing queued, the line stays at 1 and the timer stops. A later assert strobe then drives the line low on the next cycle.
- R5: In stretch mode, a chip-select event while the line is 0 drives it to 1 on the next cycle and starts a fresh high phase of T cycles.
- R6: In stretch mode, a release strobe while the line is 0 behaves like a chip-select event. A release strobe while the line is 1 leaves the line unchanged and cancels any queued assert.
- R7: In stretch mode, an assert strobe while the line is 0 has no effect on the line and does not lengthen the low phase.
- R8: `accept_o` is 1 in the cycle of an assert strobe when stretch mode is active, and 0 when it is not.
- R9: With `en_i` at 0 (disabled mode), an assert strobe gives a single low pulse of exactly L = (CLK_HZ/1_000_000)*SHORT_US cycles. Chip-select events, release strobes and assert strobes during that pulse have no effect on it.
- R10: A stop strobe, or any change of `en_i`, stops the timer, clears a queued assert and drives the line to 1 on the next cycle. Stretch mode then follows `en_i`, and the next assert strobe acts at once.
- R11: A chip-select event in the same cycle as an assert strobe takes priority, and the assert strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en_i | input | 1 | Stretch mode select; each change reinitialises the block |
| stop_i | input | 1 | Reinitialise strobe |
| assert_rq_i | input | 1 | Assert request strobe |
| release_rq_i | input | 1 | Release request strobe |
| cs_evt_i | input | 1 | Host chip-select asserted event strobe |
| irq_n_o | output | 1 | Active-low ready/interrupt line |
| accept_o | output | 1 | Assert strobe taken by stretch path |

## Verification
The hardest state to reach from the ports is a queued assert. It exists only while the line is high and the high-phase timer is still running. The stimulus gets there by issuing an assert strobe on the very first high cycle after a full low phase, or on the cycle right after a chip-select release. It then counts the high cycles that follow, to confirm that the fall lands exactly on the timeout. The same state is reached again and then cleared by a release strobe or a stop strobe. After that, the line is watched for well over a full phase to confirm that the queued fall never happens.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef struct packed {
    logic asrt;
    logic rel;
    logic cs;
  } irqs_req_t;

  function automatic int unsigned us_ticks(input int unsigned hz, input int unsigned us);
    return (hz / 1000000) * us;
  endfunction

endpackage

// File: rtl/irqs_timer.sv
module irqs_timer #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic stop_i,
  output logic run_o,
  output logic exp_o
);
  localparam int unsigned W = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [W-1:0] TOP = W'(LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         upd_en;

  assign upd_en = stop_i | load_i | run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (stop_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (load_i) begin
      run_d = 1'b1;
      cnt_d = TOP;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;
  assign exp_o = run_q & (cnt_q == '0);
endmodule

// File: rtl/irqs_phase_ctrl.sv
module irqs_phase_ctrl
  import irqs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      init_i,
  input  logic      active_i,
  input  irqs_req_t req_i,
  input  logic      t_run_i,
  input  logic      t_exp_i,
  output logic      t_load_o,
  output logic      level_o,
  output logic      pend_o
);
  logic level_q, level_d;
  logic pend_q, pend_d;
  logic drop;

  assign drop = req_i.cs | req_i.rel;

  always_comb begin
    level_d  = level_q;
    pend_d   = pend_q;
    t_load_o = 1'b0;
    if (init_i) begin
      level_d = 1'b0;
      pend_d  = 1'b0;
    end else if (active_i) begin
      if (drop) begin
        if (level_q) begin
          level_d  = 1'b0;
          t_load_o = 1'b1;
        end else begin
          pend_d = 1'b0;
        end
      end else if (t_exp_i) begin
        if (level_q) begin
          level_d  = 1'b0;
          t_load_o = 1'b1;
        end else if (pend_q | req_i.asrt) begin
          level_d  = 1'b1;
          pend_d   = 1'b0;
          t_load_o = 1'b1;
        end
      end else if (req_i.asrt && !level_q) begin
        if (t_run_i) begin
          pend_d = 1'b1;
        end else begin
          level_d  = 1'b1;
          t_load_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      pend_q  <= pend_d;
    end
  end

  assign level_o = level_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irqs_short_pulse.sv
module irqs_short_pulse #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic fire_i,
  output logic low_o
);
  localparam int unsigned W = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [W-1:0] TOP = W'(LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         busy_q, busy_d;
  logic         upd_en;

  assign upd_en = init_i | fire_i | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (init_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (fire_i) begin
      busy_d = 1'b1;
      cnt_d  = TOP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign low_o = busy_q;
endmodule

// File: rtl/irq_stretch.sv
module irq_stretch
  import irqs_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 250000000,
  parameter int unsigned MIN_US   = 100,
  parameter int unsigned SHORT_US = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_i,
  input  logic assert_rq_i,
  input  logic release_rq_i,
  input  logic cs_evt_i,
  output logic irq_n_o,
  output logic accept_o
);
  localparam int unsigned P     = us_ticks(CLK_HZ, MIN_US);
  localparam int unsigned L_RAW = us_ticks(CLK_HZ, SHORT_US);
  localparam int unsigned L     = (L_RAW == 0) ? 1 : L_RAW;

  irqs_req_t req;
  logic en_q, stretch_q;
  logic init;
  logic level, pend, short_low;

  assign req.asrt = assert_rq_i;
  assign req.rel  = release_rq_i;
  assign req.cs   = cs_evt_i;

  assign init = stop_i | (en_i ^ en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      stretch_q <= 1'b0;
    end else if (init) begin
      en_q      <= en_i;
      stretch_q <= en_i & (P != 0);
    end
  end

  generate
    if (P > 0) begin : g_stretch
      logic t_load, t_run, t_exp;

      irqs_timer #(.LEN(P)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (t_load),
        .stop_i (init),
        .run_o  (t_run),
        .exp_o  (t_exp)
      );

      irqs_phase_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .init_i   (init),
        .active_i (stretch_q),
        .req_i    (req),
        .t_run_i  (t_run),
        .t_exp_i  (t_exp),
        .t_load_o (t_load),
        .level_o  (level),
        .pend_o   (pend)
      );
    end else begin : g_bypass
      assign level = 1'b0;
      assign pend  = 1'b0;
    end
  endgenerate

  irqs_short_pulse #(.LEN(L)) u_short (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init),
    .fire_i (assert_rq_i & ~stretch_q & ~init),
    .low_o  (short_low)
  );

  assign irq_n_o  = ~(level | short_low);
  assign accept_o = assert_rq_i & stretch_q;
endmodule

// File: rtl/irq_stretch_chk.sv
module irq_stretch_chk #(
  parameter int unsigned LOW_TICKS = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_n_o,
  input logic cs_evt_i,
  input logic release_rq_i,
  input logic init_i,
  input logic stretch_i,
  input logic pend_i
);
  localparam int unsigned SAT = LOW_TICKS + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic          prev_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      run_q  <= CW'(SAT);
    end else begin
      prev_q <= irq_n_o;
      if (irq_n_o != prev_q)      run_q <= CW'(1);
      else if (run_q < CW'(SAT))  run_q <= run_q + 1'b1;
    end
  end

  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_n_o && !prev_q && stretch_i && !$past(cs_evt_i || release_rq_i || init_i))
      |-> (run_q == CW'(LOW_TICKS))); // R2

  AST_INIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> irq_n_o); // R10

  AST_CS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_evt_i && stretch_i && !init_i) |=> irq_n_o); // R5

  AST_QUEUE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> irq_n_o); // R3

  AST_CANCEL_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_evt_i || release_rq_i) && stretch_i && !init_i) |=> !pend_i); // R6
endmodule

bind irq_stretch irq_stretch_chk #(.LOW_TICKS(P)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_n_o      (irq_n_o),
  .cs_evt_i     (cs_evt_i),
  .release_rq_i (release_rq_i),
  .init_i       (init),
  .stretch_i    (stretch_q),
  .pend_i       (pend)
);

// File: tb/irq_stretch_test.sv
module irq_stretch_test;
  localparam int unsigned HZ = 10000000;
  localparam int T  = 1000;  // (HZ/1e6)*100
  localparam int LS = 40;    // (HZ/1e6)*4

  logic clk = 1'b0;
  logic rst_n, en, stop, asrt, rel, cs;
  logic irq_n, acc;
  int   checks = 0;
  int   fails  = 0;

  always #2 clk = ~clk;

  irq_stretch #(.CLK_HZ(HZ), .MIN_US(100), .SHORT_US(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .stop_i(stop),
    .assert_rq_i(asrt), .release_rq_i(rel), .cs_evt_i(cs),
    .irq_n_o(irq_n), .accept_o(acc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe inputs for one cycle; returns at the next negedge, accept sampled
  task automatic pulse(input logic a, input logic r, input logic c, input logic s, output logic acc_seen);
    asrt = a; rel = r; cs = c; stop = s;
    #1 acc_seen = acc;
    @(negedge clk);
    asrt = 0; rel = 0; cs = 0; stop = 0;
  endtask

  task automatic run_len(input logic lvl, input int cap, output int n);
    n = 0;
    while (irq_n == lvl && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (T + 10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(irq_n == 1'b1, "R1 line idle", irq_n, 1);
    chk(acc == 1'b0, "R1 accept", acc, 0);
  endtask

  task automatic t_basic_and_queue();
    logic a; int n;
    pulse(1, 0, 0, 0, a);
    chk(a == 1'b1, "R8 accept in stretch", a, 1);
    run_len(0, 3 * T, n);
    chk(n == T, "R2 low width", n, T);
    pulse(1, 0, 0, 0, a);            // first high cycle: queued
    run_len(1, 3 * T, n);
    chk(n == T - 1, "R3 queued fall at high timeout", n, T - 1);
    run_len(0, 3 * T, n);
    chk(n == T, "R3 low width after queue", n, T);
    repeat (T + 5) @(negedge clk);
    chk(irq_n == 1'b1, "R4 stays high after timeout", irq_n, 1);
    pulse(1, 0, 0, 0, a);
    chk(irq_n == 1'b0, "R4 immediate assert after idle", irq_n, 0);
    run_len(0, 3 * T, n);
    settle();
  endtask

  task automatic t_cs_release();
    logic a; int n;
    pulse(1, 0, 0, 0, a);
    repeat (99) @(negedge clk);
    pulse(0, 0, 1, 0, a);
    chk(irq_n == 1'b1, "R5 early release on chip-select", irq_n, 1);
    pulse(1, 0, 0, 0, a);
    run_len(1, 3 * T, n);
    chk(n == T - 1, "R5 high phase restarts", n, T - 1);
    run_len(0, 3 * T, n);
    chk(n == T, "R5 following low width", n, T);
    settle();
  endtask

  task automatic t_release();
    logic a; int n;
    pulse(1, 0, 0, 0, a);
    repeat (50) @(negedge clk);
    pulse(0, 1, 0, 0, a);
    chk(irq_n == 1'b1, "R6 release strobe while low", irq_n, 1);
    pulse(1, 0, 0, 0, a);            // queued
    pulse(0, 1, 0, 0, a);            // cancels queue
    run_len(1, 2 * T + 10, n);
    chk(n == 2 * T + 10, "R6 queued assert cancelled", n, 2 * T + 10);
  endtask

  task automatic t_duplicate();
    logic a; int n;
    pulse(1, 0, 0, 0, a);
    repeat (9) @(negedge clk);
    pulse(1, 0, 0, 0, a);
    chk(a == 1'b1, "R7 duplicate still accepted", a, 1);
    run_len(0, 3 * T, n);
    chk(n == T - 10, "R7 duplicate does not extend low", n, T - 10);
    settle();
  endtask

  task automatic t_priority();
    logic a; int n;
    pulse(1, 0, 1, 0, a);
    run_len(1, T + 10, n);
    chk(n == T + 10, "R11 chip-select beats assert", n, T + 10);
  endtask

  task automatic t_init();
    logic a; int n;
    pulse(1, 0, 0, 0, a);
    repeat (3) @(negedge clk);
    pulse(0, 0, 0, 1, a);
    chk(irq_n == 1'b1, "R10 stop forces high", irq_n, 1);
    pulse(1, 0, 0, 0, a);
    chk(irq_n == 1'b0, "R10 assert acts at once after stop", irq_n, 0);
    pulse(0, 0, 1, 0, a);
    pulse(1, 0, 0, 0, a);            // queued
    pulse(0, 0, 0, 1, a);            // stop clears queue
    run_len(1, 2 * T + 10, n);
    chk(n == 2 * T + 10, "R10 stop clears queued assert", n, 2 * T + 10);
  endtask

  task automatic t_short();
    logic a; int n;
    en = 1'b0;
    repeat (3) @(negedge clk);
    pulse(1, 0, 0, 0, a);
    chk(a == 1'b0, "R8 no accept when disabled", a, 0);
    run_len(0, 3 * T, n);
    chk(n == LS, "R9 short pulse width", n, LS);
    repeat (5) @(negedge clk);
    pulse(1, 0, 0, 0, a);
    repeat (4) @(negedge clk);
    pulse(0, 1, 1, 0, a);
    pulse(1, 0, 0, 0, a);
    run_len(0, 3 * T, n);
    chk(n == LS - 6, "R9 strobes ignored during short pulse", n, LS - 6);
  endtask

  initial begin
    rst_n = 0; en = 0; stop = 0; asrt = 0; rel = 0; cs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    en = 1'b1;
    repeat (3) @(negedge clk);
    t_basic_and_queue();
    t_cs_release();
    t_release();
    t_duplicate();
    t_priority();
    t_init();
    t_short();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule